// File: doc/BRIEF.md
# SPI Serial Clock Prescaler

This block derives an SPI serial clock from the system clock. It divides by a ratio that is decoded from an 8-bit configuration byte. A mode input picks one of two decodings. The legacy decoding reads a 5-bit field and gives even ratios from 4 to 30. The extended decoding multiplies a 4-bit scaler by a power of two and reaches ratios up to 1920. One bit of the byte belongs to a word-width setting elsewhere, and the divider ignores it.

The block also produces two one-cycle strobes. One marks each edge into the active level of the serial clock and the other marks each edge back to the idle level. The shift logic next to this block uses them to know when to drive and when to sample. The divider reads the configuration, the enable and the polarity only at a period boundary, so a period that has started always finishes unchanged. An invalid setting, or a low enable, leaves the clock resting at the level given by the polarity input.

Top module: `spi_sclk_prescaler`

## Requirements
- R1: While reset is low, sclk equals cpol and both strobes are 0. The reset is synchronous and active low.
- R2: With ext_mode=0 the field is cfg_byte[4:0] and bits 7:5 have no effect. The clock period is 2*(field-16) system cycles, which covers the even values 4 to 30.
- R3: With ext_mode=0, a field below 0x12 is invalid. No period starts and sclk rests at the idle level.
- R4: With ext_mode=1 the ratio is cfg_byte[3:0] * 2^e, where e = {cfg_byte[7], cfg_byte[6], cfg_byte[4]} (cfg_byte[4] is the LSB). The largest ratio is 15*128 = 1920.
- R5: With ext_mode=1, cfg_byte[5] has no effect on the clock.
- R6: With ext_mode=1, a scaler cfg_byte[3:0] of 0 is invalid. No period starts and sclk rests at the idle level.
- R7: A period of P cycles opens with ceil(P/2) cycles at the active level (the inverse of cpol) and closes with floor(P/2) cycles at the idle level. For an odd P the active phase is therefore one cycle longer.
- R8: A ratio of 1 gives an output that changes level on every system cycle, so it has the same waveform as a ratio of 2.
- R9: When the clock is not running, sclk follows cpol one cycle later. The enable is read only at a period boundary, so a period already running when enable falls completes its active phase and then stays idle.
- R10: A new configuration byte or mode takes effect only at the first period boundary after it is applied. The running period keeps its length.
- R11: lead_stb is high for exactly the one cycle in which sclk has just entered the active level. trail_stb is high for exactly the one cycle in which sclk has just returned to idle. There is one of each per period, and they never overlap.
- R12: The polarity is captured when a period starts. A change of cpol during a period does not move sclk until the next period starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_mode | input | 1 | 0 selects the legacy decoding, 1 selects the extended decoding |
| cfg_byte | input | 8 | Configuration byte holding the prescale field |
| cpol | input | 1 | Idle level of the serial clock |
| enable | input | 1 | Lets periods start at a boundary |
| sclk | output | 1 | Divided serial clock (registered) |
| lead_stb | output | 1 | One-cycle strobe on the edge into the active level |
| trail_stb | output | 1 | One-cycle strobe on the edge back to idle |

## Verification
The bench builds the block with its default parameters: a 4-bit scaler, a 3-bit exponent and a 5-bit legacy field. With these values the ratio register is 11 bits wide, so both the smallest extended case (ratio 1, folded to 2) and the largest (1920) can be measured in a few thousand cycles. One table loop measures the period, the active-phase length and the strobe count for every legal width of the legacy field and for a spread of scaler and exponent values. Directed sequences then change the byte, cpol and enable in the middle of a period to show that these inputs are held until the next boundary.

// File: rtl/sclk_div_pkg.sv
// Package: shared widths and constants for the SPI serial clock prescaler.
// Assumes the 8-bit configuration byte layout described in the brief.
package sclk_div_pkg;
    localparam int CFG_W      = 8;                              // configuration byte width
    localparam int SCALER_W   = 4;                              // extended scaler width
    localparam int EXP_W      = 3;                              // extended exponent width
    localparam int LEG_W      = SCALER_W + 1;                   // legacy field width
    localparam int RATIO_W    = SCALER_W + (1 << EXP_W) - 1;    // enough for 15 << 7
    localparam int WIDTH_BIT  = 5;                              // word-width select, not ours
    localparam logic [LEG_W-1:0] LEG_MIN = LEG_W'(18);          // smallest legal legacy field
endpackage

// File: rtl/sclk_ratio_decode.sv
// Module: sclk_ratio_decode
// Turns the prescale bits into a period length, the active-phase length and
// a valid flag. Purely combinational. Assumes that the caller has already
// dropped the word-width bit and passes only the bits the divider owns.
module sclk_ratio_decode
    import sclk_div_pkg::*;
#(
    parameter int P_SCALER_W = SCALER_W,
    parameter int P_EXP_W    = EXP_W,
    parameter int P_RATIO_W  = RATIO_W,
    parameter logic [P_SCALER_W:0] P_LEG_MIN = LEG_MIN
) (
    input  logic                    ext_mode,
    input  logic [P_SCALER_W:0]     low_field,   // legacy field / {exp LSB, scaler}
    input  logic [P_EXP_W-2:0]      exp_upper,   // upper exponent bits (extended)
    output logic                    valid,
    output logic [P_RATIO_W-1:0]    period,
    output logic [P_RATIO_W-1:0]    active_len
);
    logic [P_SCALER_W-1:0] scaler;
    logic [P_EXP_W-1:0]    expo;
    logic [P_RATIO_W-1:0]  ratio;
    logic [P_RATIO_W:0]    len_sum;

    assign scaler = low_field[P_SCALER_W-1:0];
    assign expo   = {exp_upper, low_field[P_SCALER_W]};

    // Purpose: pick the ratio and its legality for the selected decoding.
    always_comb begin
        if (ext_mode) begin
            valid = (scaler != '0);
            ratio = P_RATIO_W'(scaler) << expo;
        end else begin
            valid = (low_field >= P_LEG_MIN);
            ratio = P_RATIO_W'({scaler, 1'b0});
        end
    end

    // Purpose: fold ratio 1 onto a two-cycle period and size the active phase.
    always_comb begin
        period     = (ratio == P_RATIO_W'(1)) ? P_RATIO_W'(2) : ratio;
        len_sum    = {1'b0, period} + (P_RATIO_W+1)'(1);
        active_len = len_sum[P_RATIO_W:1];
    end
endmodule

// File: rtl/sclk_period_counter.sv
// Module: sclk_period_counter
// Counts system cycles within one serial clock period. It reads the next
// period length and the go request only at a boundary (while idle or in the
// last cycle of a period), and it flags the cycle where the active phase ends.
// Assumes period_in >= 2 and 1 <= active_in < period_in whenever go is high.
module sclk_period_counter #(
    parameter int P_RATIO_W = 11
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  go,
    input  logic [P_RATIO_W-1:0]  period_in,
    input  logic [P_RATIO_W-1:0]  active_in,
    output logic                  run,
    output logic                  start,
    output logic                  stop,
    output logic                  half_hit
);
    localparam logic [P_RATIO_W-1:0] ONE = P_RATIO_W'(1);

    logic                 run_q;
    logic [P_RATIO_W-1:0] cnt_q;
    logic [P_RATIO_W-1:0] per_q;
    logic [P_RATIO_W-1:0] act_q;
    logic                 at_end;
    logic                 boundary;

    assign at_end   = run_q && (cnt_q == per_q - ONE);
    assign boundary = !run_q || at_end;
    assign start    = boundary && go;
    assign stop     = boundary && !go;
    assign half_hit = run_q && !at_end && ((cnt_q + ONE) == act_q);
    assign run      = run_q;

    // Purpose: advance the cycle count and latch a new period at a boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            cnt_q <= '0;
            per_q <= '0;
            act_q <= '0;
        end else begin
            if (boundary) run_q <= go;
            if (start) begin
                cnt_q <= '0;
                per_q <= period_in;
                act_q <= active_in;
            end else if (stop) begin
                cnt_q <= '0;
            end else if (run_q) begin
                cnt_q <= cnt_q + ONE;
            end
        end
    end

    // R7: the count never leaves the latched period while running.
    a_r7_count_in_period: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> (cnt_q < per_q));

    // R10: the latched period holds until the cycle after a boundary.
    a_r10_period_held: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && $past(run_q) && !$past(at_end)) |-> $stable(per_q));

    // R3 / R6: with go low while idle, the counter stays idle.
    a_r6_no_start_without_go: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !go) |=> !run_q);
endmodule

// File: rtl/sclk_edge_out.sv
// Module: sclk_edge_out
// Drives the registered serial clock and its two edge strobes from the
// counter events. It captures the polarity at each period start so that a
// polarity change in mid-period cannot cut a phase short. Assumes start and
// half_hit are never high in the same cycle.
module sclk_edge_out (
    input  logic clk,
    input  logic rst_n,
    input  logic cpol,
    input  logic run,
    input  logic start,
    input  logic stop,
    input  logic half_hit,
    output logic sclk,
    output logic lead,
    output logic trail
);
    logic pol_q;

    // Purpose: register sclk, the strobes and the captured polarity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol_q <= cpol;
            sclk  <= cpol;
            lead  <= 1'b0;
            trail <= 1'b0;
        end else begin
            lead  <= start;
            trail <= half_hit;
            if (start || !run) pol_q <= cpol;
            if (start)         sclk <= ~cpol;
            else if (half_hit) sclk <= pol_q;
            else if (stop)     sclk <= cpol;
        end
    end

    // R11: the two strobes never overlap.
    a_r11_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(lead && trail));

    // R11: a trailing strobe always comes with a real level change.
    a_r11_trail_is_edge: assert property (@(posedge clk) disable iff (!rst_n)
        trail |-> (sclk != $past(sclk)));

    // R11: inside a run every level change of sclk carries a strobe.
    a_r11_run_edges_strobed: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && (sclk != $past(sclk))) |-> (lead || trail));

    // R9: while not running, sclk is the polarity input of one cycle earlier.
    a_r9_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (sclk == $past(cpol)));
endmodule

// File: rtl/spi_sclk_prescaler.sv
// Module: spi_sclk_prescaler (top)
// SPI serial clock generator with legacy and extended prescale decodings.
// It splits the configuration byte, decodes the ratio, counts the period and
// drives the registered clock and strobes. Assumes all inputs are
// synchronous to clk. The word-width bit of the byte is not used here.
module spi_sclk_prescaler
    import sclk_div_pkg::*;
#(
    parameter int P_CFG_W    = CFG_W,
    parameter int P_SCALER_W = SCALER_W,
    parameter int P_EXP_W    = EXP_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ext_mode,
    input  logic [P_CFG_W-1:0] cfg_byte,
    input  logic               cpol,
    input  logic               enable,
    output logic               sclk,
    output logic               lead_stb,
    output logic               trail_stb
);
    localparam int L_RATIO_W = P_SCALER_W + (1 << P_EXP_W) - 1;
    localparam int L_UP_LSB  = P_CFG_W - (P_EXP_W - 1);

    logic                 dec_valid;
    logic [L_RATIO_W-1:0] dec_period;
    logic [L_RATIO_W-1:0] dec_active;
    logic                 go;
    logic                 run;
    logic                 start;
    logic                 stop;
    logic                 half_hit;

    sclk_ratio_decode #(
        .P_SCALER_W (P_SCALER_W),
        .P_EXP_W    (P_EXP_W),
        .P_RATIO_W  (L_RATIO_W),
        .P_LEG_MIN  (LEG_MIN)
    ) u_decode (
        .ext_mode   (ext_mode),
        .low_field  (cfg_byte[P_SCALER_W:0]),
        .exp_upper  (cfg_byte[P_CFG_W-1:L_UP_LSB]),
        .valid      (dec_valid),
        .period     (dec_period),
        .active_len (dec_active)
    );

    assign go = enable && dec_valid;

    sclk_period_counter #(
        .P_RATIO_W (L_RATIO_W)
    ) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .period_in (dec_period),
        .active_in (dec_active),
        .run       (run),
        .start     (start),
        .stop      (stop),
        .half_hit  (half_hit)
    );

    sclk_edge_out u_edges (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpol     (cpol),
        .run      (run),
        .start    (start),
        .stop     (stop),
        .half_hit (half_hit),
        .sclk     (sclk),
        .lead     (lead_stb),
        .trail    (trail_stb)
    );

    // R5: toggling only the word-width bit in extended mode leaves the period unchanged.
    a_r5_width_bit_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_mode && $past(ext_mode) && !$stable(cfg_byte[WIDTH_BIT])
         && $stable(cfg_byte[P_CFG_W-1:WIDTH_BIT+1])
         && $stable(cfg_byte[WIDTH_BIT-1:0])) |-> $stable(dec_period));

    // R1: the cycle after a reset cycle shows idle outputs.
    a_r1_reset_idle: assert property (@(posedge clk)
        !$past(rst_n) |-> (!lead_stb && !trail_stb && sclk == $past(cpol)));
endmodule

// File: tb/test_spi_sclk_prescaler.sv
// Bench for spi_sclk_prescaler: a table of byte settings with their expected
// period and active length, then directed runs for reset, mid-period changes
// and enable removal. Inputs are driven and outputs sampled on falling edges.
module test_spi_sclk_prescaler;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 150000;
    localparam int  NV         = 16;
    localparam int  LIMIT      = 5000;

    // {ext_mode, cfg_byte, period, active cycles}; period 0 marks an invalid setting
    localparam logic [32:0] VEC [NV] = '{
        {1'b0, 8'h12, 12'd4,    12'd2},    // R2 smallest legacy
        {1'b0, 8'h13, 12'd6,    12'd3},    // R2
        {1'b0, 8'h1F, 12'd30,   12'd15},   // R2 largest legacy
        {1'b0, 8'hF5, 12'd10,   12'd5},    // R2 upper bits ignored
        {1'b0, 8'h11, 12'd0,    12'd0},    // R3 below minimum
        {1'b0, 8'h05, 12'd0,    12'd0},    // R3 no base bit
        {1'b1, 8'h01, 12'd2,    12'd1},    // R8 ratio 1
        {1'b1, 8'h10, 12'd0,    12'd0},    // R6 scaler zero
        {1'b1, 8'h03, 12'd3,    12'd2},    // R4 odd ratio (R7)
        {1'b1, 8'h25, 12'd5,    12'd3},    // R5 width bit set
        {1'b1, 8'hE0, 12'd0,    12'd0},    // R6 scaler zero, exponent 7
        {1'b1, 8'h17, 12'd14,   12'd7},    // R4 e=1
        {1'b1, 8'h49, 12'd36,   12'd18},   // R4 e=2
        {1'b1, 8'hC2, 12'd128,  12'd64},   // R4 e=6
        {1'b1, 8'h05, 12'd5,    12'd3},    // R5 width bit clear
        {1'b1, 8'hDF, 12'd1920, 12'd960}   // R4 largest
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic       ext_mode;
    logic [7:0] cfg_byte;
    logic       cpol;
    logic       enable;
    logic       sclk;
    logic       lead_stb;
    logic       trail_stb;

    int checks   = 0;
    int failures = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    spi_sclk_prescaler i_spi_sclk_prescaler (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_mode  (ext_mode),
        .cfg_byte  (cfg_byte),
        .cpol      (cpol),
        .enable    (enable),
        .sclk      (sclk),
        .lead_stb  (lead_stb),
        .trail_stb (trail_stb)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Purpose: end a hung run as a failure and still print the summary.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == WATCHDOG && !done) begin
            checks   = checks + 1;
            failures = failures + 1;
            $display("FAIL watchdog (all requirements) actual=%0d expected<%0d", cycles, WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            failures = failures + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_lead(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < LIMIT; i++) begin
            @(negedge clk);
            if (lead_stb) begin
                seen = 1'b1;
                break;
            end
        end
    endtask

    // Measures one period from a leading strobe to the next one.
    task automatic measure(input logic pol, output int per, output int act, output int trails);
        bit seen;
        per = 0; act = 0; trails = 0;
        wait_lead(seen);
        if (!seen) return;
        per = 1;
        act = (sclk != pol) ? 1 : 0;
        for (int i = 0; i < LIMIT; i++) begin
            @(negedge clk);
            if (lead_stb) break;
            per++;
            if (sclk != pol) act++;
            if (trail_stb) trails++;
        end
    endtask

    // Counts leading strobes and off-level samples over a window.
    task automatic quiet_window(input int len, input logic pol, output int leads, output int bad);
        leads = 0; bad = 0;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (lead_stb) leads++;
            if (sclk != pol) bad++;
        end
    endtask

    initial begin
        int per, act, trails, leads, bad, cnt;
        bit seen;
        string tag;
        rst_n = 1'b0; ext_mode = 1'b0; cfg_byte = 8'h12; cpol = 1'b1; enable = 1'b1;

        // R1: reset state with polarity high, even with enable and a valid byte
        repeat (3) @(negedge clk);
        check(sclk == 1'b1 && !lead_stb && !trail_stb, "R1 reset idle cpol=1", sclk, 1);
        cpol = 1'b0;
        @(negedge clk);
        check(sclk == 1'b0 && !lead_stb && !trail_stb, "R1 reset idle cpol=0", sclk, 0);

        // R9: released but disabled, the clock tracks cpol
        enable = 1'b0;
        rst_n = 1'b1;
        quiet_window(20, 1'b0, leads, bad);
        check(leads == 0 && bad == 0, "R9 disabled stays idle", leads + bad, 0);
        cpol = 1'b1;
        @(negedge clk);
        check(sclk == 1'b1, "R9 idle follows cpol", sclk, 1);
        cpol = 1'b0;
        @(negedge clk);

        // Table walk: R2 R3 R4 R5 R6 R7 R8 R11
        enable = 1'b1;
        for (int i = 0; i < NV; i++) begin
            ext_mode = VEC[i][32];
            cfg_byte = VEC[i][31:24];
            if (VEC[i][23:12] == 12'd0) begin
                tag = ext_mode ? "R6" : "R3";
                repeat (64) @(negedge clk);
                quiet_window(64, 1'b0, leads, bad);
                check(leads == 0 && bad == 0, tag, leads + bad, 0);
            end else begin
                tag = ext_mode ? "R4" : "R2";
                measure(1'b0, per, act, trails);
                check(per == int'(VEC[i][23:12]), tag, per, int'(VEC[i][23:12]));
                check(act == int'(VEC[i][11:0]), "R7 active phase", act, int'(VEC[i][11:0]));
                check(trails == 1, "R11 one trail per period", trails, 1);
            end
        end

        // R10: a byte change in mid-period waits for the boundary
        ext_mode = 1'b0; cfg_byte = 8'h1F;
        measure(1'b0, per, act, trails);
        wait_lead(seen);
        cnt = 1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            cnt++;
        end
        cfg_byte = 8'h12;
        for (int i = 0; i < LIMIT; i++) begin
            @(negedge clk);
            if (lead_stb) break;
            cnt++;
        end
        check(cnt == 30, "R10 running period kept", cnt, 30);
        measure(1'b0, per, act, trails);
        check(per == 4, "R10 new ratio after boundary", per, 4);

        // R12: a cpol change in mid-period is held until the next start
        cfg_byte = 8'h15;
        measure(1'b0, per, act, trails);
        wait_lead(seen);
        cpol = 1'b1;
        repeat (2) @(negedge clk);
        check(sclk == 1'b1, "R12 active level held", sclk, 1);
        wait_lead(seen);
        check(seen && sclk == 1'b0, "R12 new polarity at start", sclk, 0);
        measure(1'b1, per, act, trails);
        check(per == 10 && act == 5, "R12 inverted period", per * 100 + act, 1005);

        // R9: enable removed at a lead completes the active phase then idles
        cpol = 1'b0;
        measure(1'b0, per, act, trails);
        wait_lead(seen);
        enable = 1'b0;
        cnt = 0;
        for (int i = 0; i < LIMIT; i++) begin
            if (sclk == 1'b0) break;
            cnt++;
            @(negedge clk);
        end
        check(cnt == 5, "R9 active phase finished", cnt, 5);
        quiet_window(40, 1'b0, leads, bad);
        check(leads == 0 && bad == 0, "R9 no restart when disabled", leads + bad, 0);

        // R8: ratio 1 toggles every cycle once restarted
        ext_mode = 1'b1; cfg_byte = 8'h01; enable = 1'b1;
        wait_lead(seen);
        @(negedge clk);
        check(sclk == 1'b0 && trail_stb, "R8 toggles next cycle", sclk, 0);
        @(negedge clk);
        check(sclk == 1'b1 && lead_stb, "R8 toggles again", sclk, 1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule